// File: doc/BRIEF.md
# Valid-Mode Fixed-Point FIR Engine

This block runs one finite-impulse-response pass over a block of samples that already sits in a local sample memory. The coefficients sit in a second memory. For every position where the coefficient window lies wholly inside the sample block, it forms one output and writes it to an output memory. Positions where the window would run past the edge of the block are not computed.

A command is launched with a one-cycle `start` pulse that carries an operation code, the tap count, the sample count, three element-format codes and a conjugate flag. Sample, coefficient and result elements can each be real or complex, in Q31 or Q15. Every product is summed at full precision. The sum is then rounded and clamped to the result format, and any clamp sets a sticky `overflow` flag. When the final result has been written, `done` pulses for one cycle.

The three memories use plain synchronous ports. A read enable and address issued in one cycle return data in the next cycle. A write takes effect in the cycle where the write enable is high.

Top module: `fir_valid_engine`

## Requirements
- R1: A `start` pulse seen while idle is taken only if `op_code` is 0 (FIR), `tap_count` is between 1 and MAX_TAPS, and `data_len` is at least `tap_count`. Any other `start` produces no memory write and no `done` pulse, and leaves `overflow` as it was.
- R2: An accepted command writes exactly `data_len - tap_count + 1` results, to output addresses 0, 1, 2 and upward, in that order.
- R3: Result n is the sum over k = 0 .. taps-1 of x[n+k]·c[k], formed at full precision before any rounding.
- R4: Every element occupies one 64-bit word, with the real part in bits [31:0] and the imaginary part in bits [63:32]. The format codes are 0 = real Q31, 1 = real Q15, 2 = complex Q31 and 3 = complex Q15. A Q15 value is taken from the low 16 bits of its half, and the upper 16 bits of that half are ignored. For real formats the imaginary half is ignored and treated as zero.
- R5: Complex samples and complex coefficients are multiplied as complex numbers. When `conj_coef` is set, the imaginary part of each coefficient is negated before it is multiplied.
- R6: A result is rounded half-up at its own least significant bit. This means adding half an LSB and then shifting right arithmetically.
- R7: A result that lies outside the range of the output format is clamped to the nearest limit and sets `overflow`. The flag stays set until the next accepted command clears it.
- R8: For a real output format the imaginary half of the written word is zero. Q15 results are sign-extended into their 32-bit half.
- R9: `done` is high for exactly one cycle, in the cycle right after the last result write.
- R10: All configuration inputs are captured when the command is accepted. Changing them while the command runs has no effect on the results.
- R11: While reset is active, and until a command is accepted after reset, `done`, `overflow` and all memory enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle command launch |
| op_code | input | 6 | Operation code; 0 selects FIR |
| tap_count | input | TAP_W | Number of coefficients |
| data_len | input | LEN_W | Number of input samples |
| in_fmt | input | 2 | Sample element format |
| coef_fmt | input | 2 | Coefficient element format |
| out_fmt | input | 2 | Result element format |
| conj_coef | input | 1 | Negate the imaginary part of each coefficient |
| x_rd_en | output | 1 | Sample memory read enable |
| x_rd_addr | output | LEN_W | Sample memory read address |
| x_rd_data | input | 64 | Sample word, valid one cycle after the read |
| c_rd_en | output | 1 | Coefficient memory read enable |
| c_rd_addr | output | TAP_W | Coefficient memory read address |
| c_rd_data | input | 64 | Coefficient word, valid one cycle after the read |
| y_wr_en | output | 1 | Output memory write enable |
| y_wr_addr | output | LEN_W | Output memory write address |
| y_wr_data | output | 64 | Result word |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Sticky saturation flag |

## Verification
The bench builds the engine with MAX_TAPS = 16 and LEN_W = 8. With that tap limit, a command at the full tap count (16 taps over 16 samples, one result) fits in a short run. A tap count of 17 is still expressible on the 5-bit tap port, so the limit can be tested from both sides. The 8-bit length keeps the sample memory at 256 words while still covering one-tap commands, mixed real and complex formats, conjugation, exact rounding midpoints and clamping in both directions.

// File: rtl/fir_eng_pkg.sv
package fir_eng_pkg;

  localparam int HALF_W = 32;
  localparam int ELEM_W = 2 * HALF_W;
  localparam int OPC_W  = 6;
  localparam logic [OPC_W-1:0] OPC_FIR = '0;

  typedef enum logic [1:0] {
    FMT_REAL_Q31 = 2'd0,
    FMT_REAL_Q15 = 2'd1,
    FMT_CPLX_Q31 = 2'd2,
    FMT_CPLX_Q15 = 2'd3
  } elem_fmt_e;

  typedef struct packed {
    elem_fmt_e in_fmt;
    elem_fmt_e coef_fmt;
    elem_fmt_e out_fmt;
    logic      conj;
  } job_cfg_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_WAIT,
    SQ_WRITE,
    SQ_DONE
  } seq_state_e;

  function automatic logic fmt_is_cplx(elem_fmt_e f);
    return f[1];
  endfunction

  function automatic logic fmt_is_q15(elem_fmt_e f);
    return f[0];
  endfunction

  // Align either Q format onto a Q31 grid.
  function automatic logic signed [HALF_W-1:0] lift_q31(logic [HALF_W-1:0] half, elem_fmt_e f);
    if (fmt_is_q15(f)) return {half[HALF_W/2-1:0], {(HALF_W/2){1'b0}}};
    return half;
  endfunction

  function automatic logic signed [HALF_W-1:0] real_part(logic [ELEM_W-1:0] w, elem_fmt_e f);
    return lift_q31(w[HALF_W-1:0], f);
  endfunction

  function automatic logic signed [HALF_W-1:0] imag_part(logic [ELEM_W-1:0] w, elem_fmt_e f);
    if (!fmt_is_cplx(f)) return '0;
    return lift_q31(w[ELEM_W-1:HALF_W], f);
  endfunction

endpackage

// File: rtl/fir_seq_ctrl.sv
module fir_seq_ctrl import fir_eng_pkg::*; #(
  parameter int MAX_TAPS = 256,
  parameter int LEN_W    = 16,
  parameter int TAP_W    = $clog2(MAX_TAPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPC_W-1:0] op_code,
  input  logic [TAP_W-1:0] tap_count,
  input  logic [LEN_W-1:0] data_len,
  output logic             accept,
  output logic             rd_en,
  output logic [LEN_W-1:0] x_addr,
  output logic [TAP_W-1:0] c_addr,
  output logic             dat_vld,
  output logic             dat_first,
  output logic             wr_en,
  output logic [LEN_W-1:0] wr_addr,
  output logic             done
);

  seq_state_e       state_q;
  logic [TAP_W-1:0] k_q, taps_q;
  logic [LEN_W-1:0] n_q, nout_q;
  logic             dat_vld_q, dat_first_q;
  logic             legal, last_tap, last_out;

  assign legal = (op_code == OPC_FIR) && (tap_count != '0) &&
                 (32'(tap_count) <= MAX_TAPS) && (32'(data_len) >= 32'(tap_count));
  assign accept   = (state_q == SQ_IDLE) && start && legal;
  assign last_tap = (k_q == taps_q - TAP_W'(1));
  assign last_out = (n_q == nout_q - LEN_W'(1));

  assign rd_en     = (state_q == SQ_ISSUE);
  assign x_addr    = n_q + LEN_W'(k_q);
  assign c_addr    = k_q;
  assign dat_vld   = dat_vld_q;
  assign dat_first = dat_first_q;
  assign wr_en     = (state_q == SQ_WRITE);
  assign wr_addr   = n_q;
  assign done      = (state_q == SQ_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      k_q         <= '0;
      n_q         <= '0;
      taps_q      <= '0;
      nout_q      <= '0;
      dat_vld_q   <= 1'b0;
      dat_first_q <= 1'b0;
    end else begin
      dat_vld_q   <= (state_q == SQ_ISSUE);
      dat_first_q <= (state_q == SQ_ISSUE) && (k_q == '0);
      unique case (state_q)
        SQ_IDLE: if (accept) begin
          taps_q  <= tap_count;
          nout_q  <= data_len - LEN_W'(tap_count) + LEN_W'(1);
          k_q     <= '0;
          n_q     <= '0;
          state_q <= SQ_ISSUE;
        end
        SQ_ISSUE: if (last_tap) state_q <= SQ_WAIT;
                  else k_q <= k_q + TAP_W'(1);
        SQ_WAIT:  state_q <= SQ_WRITE;
        SQ_WRITE: if (last_out) state_q <= SQ_DONE;
                  else begin
                    n_q     <= n_q + LEN_W'(1);
                    k_q     <= '0;
                    state_q <= SQ_ISSUE;
                  end
        SQ_DONE:  state_q <= SQ_IDLE;
        default:  state_q <= SQ_IDLE;
      endcase
    end
  end

  // Tracking for the write-order check.
  logic [LEN_W-1:0] chk_prev_addr;
  logic             chk_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_prev_addr <= '0;
      chk_seen      <= 1'b0;
    end else if (accept) begin
      chk_seen <= 1'b0;
    end else if (wr_en) begin
      chk_prev_addr <= wr_addr;
      chk_seen      <= 1'b1;
    end
  end

  AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && chk_seen) |-> (wr_addr == chk_prev_addr + LEN_W'(1))); // R2
  AST_FIRST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !chk_seen) |-> (wr_addr == '0)); // R2
  AST_TAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ((c_addr < taps_q) && (x_addr >= LEN_W'(c_addr)))); // R3
  AST_IGNORED_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && start && !legal) |=> (state_q == SQ_IDLE)); // R1
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit import fir_eng_pkg::*; #(
  parameter int TAP_W  = 9,
  parameter int PROD_W = 2 * HALF_W + 2,
  parameter int ACC_W  = PROD_W + TAP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dat_vld,
  input  logic                    dat_first,
  input  logic [ELEM_W-1:0]       x_word,
  input  logic [ELEM_W-1:0]       c_word,
  input  job_cfg_t                cfg,
  output logic signed [ACC_W-1:0] acc_re,
  output logic signed [ACC_W-1:0] acc_im
);

  function automatic logic signed [PROD_W-1:0] mul_wide(logic signed [HALF_W-1:0] a,
                                                         logic signed [HALF_W:0]   b);
    return PROD_W'(a) * PROD_W'(b);
  endfunction

  logic signed [HALF_W-1:0] xr, xi, cr, ci;
  logic signed [HALF_W:0]   cr_x, ci_x, ci_eff;
  logic signed [PROD_W-1:0] prod_re, prod_im;

  always_comb begin
    xr      = real_part(x_word, cfg.in_fmt);
    xi      = imag_part(x_word, cfg.in_fmt);
    cr      = real_part(c_word, cfg.coef_fmt);
    ci      = imag_part(c_word, cfg.coef_fmt);
    cr_x    = (HALF_W+1)'(cr);
    ci_x    = (HALF_W+1)'(ci);
    ci_eff  = cfg.conj ? -ci_x : ci_x;
    prod_re = mul_wide(xr, cr_x) - mul_wide(xi, ci_eff);
    prod_im = mul_wide(xr, ci_eff) + mul_wide(xi, cr_x);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_re <= '0;
      acc_im <= '0;
    end else if (dat_vld) begin
      acc_re <= (dat_first ? '0 : acc_re) + ACC_W'(prod_re);
      acc_im <= (dat_first ? '0 : acc_im) + ACC_W'(prod_im);
    end
  end

endmodule

// File: rtl/fir_out_quant.sv
module fir_out_quant import fir_eng_pkg::*; #(
  parameter int ACC_W = 75
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr_fire,
  input  logic signed [ACC_W-1:0] acc_re,
  input  logic signed [ACC_W-1:0] acc_im,
  input  elem_fmt_e               out_fmt,
  output logic [ELEM_W-1:0]       wr_data,
  output logic                    sat_event,
  output logic                    overflow
);

  localparam int FRAC_ACC = 2 * (HALF_W - 1);
  localparam int SH_Q31   = FRAC_ACC - (HALF_W - 1);
  localparam int SH_Q15   = FRAC_ACC - (HALF_W/2 - 1);
  localparam logic signed [ACC_W-1:0] MAX_Q31 = ACC_W'(64'sh7FFF_FFFF);
  localparam logic signed [ACC_W-1:0] MIN_Q31 = -MAX_Q31 - 1;
  localparam logic signed [ACC_W-1:0] MAX_Q15 = ACC_W'(64'sh7FFF);
  localparam logic signed [ACC_W-1:0] MIN_Q15 = -MAX_Q15 - 1;

  typedef struct packed {
    logic              sat;
    logic [HALF_W-1:0] val;
  } qres_t;

  function automatic qres_t round_sat(logic signed [ACC_W-1:0] a, logic q15);
    logic signed [ACC_W-1:0] bias, sum, r, hi, lo;
    int sh;
    qres_t o;
    sh   = q15 ? SH_Q15 : SH_Q31;
    hi   = q15 ? MAX_Q15 : MAX_Q31;
    lo   = q15 ? MIN_Q15 : MIN_Q31;
    bias = ACC_W'(1) << (sh - 1);
    sum  = a + bias;
    r    = sum >>> sh;
    if (r > hi) begin
      o.sat = 1'b1;
      o.val = hi[HALF_W-1:0];
    end else if (r < lo) begin
      o.sat = 1'b1;
      o.val = lo[HALF_W-1:0];
    end else begin
      o.sat = 1'b0;
      o.val = r[HALF_W-1:0];
    end
    return o;
  endfunction

  qres_t q_re, q_im;
  logic  cplx_out;

  always_comb begin
    cplx_out  = fmt_is_cplx(out_fmt);
    q_re      = round_sat(acc_re, fmt_is_q15(out_fmt));
    q_im      = round_sat(acc_im, fmt_is_q15(out_fmt));
    wr_data   = {cplx_out ? q_im.val : {HALF_W{1'b0}}, q_re.val};
    sat_event = wr_fire && (q_re.sat || (cplx_out && q_im.sat));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overflow <= 1'b0;
    else if (clr)       overflow <= 1'b0;
    else if (sat_event) overflow <= 1'b1;
  end

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !overflow); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow); // R7

endmodule

// File: rtl/fir_valid_engine.sv
module fir_valid_engine import fir_eng_pkg::*; #(
  parameter  int MAX_TAPS = 256,
  parameter  int LEN_W    = 16,
  localparam int TAP_W    = $clog2(MAX_TAPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [TAP_W-1:0]  tap_count,
  input  logic [LEN_W-1:0]  data_len,
  input  logic [1:0]        in_fmt,
  input  logic [1:0]        coef_fmt,
  input  logic [1:0]        out_fmt,
  input  logic              conj_coef,
  output logic              x_rd_en,
  output logic [LEN_W-1:0]  x_rd_addr,
  input  logic [ELEM_W-1:0] x_rd_data,
  output logic              c_rd_en,
  output logic [TAP_W-1:0]  c_rd_addr,
  input  logic [ELEM_W-1:0] c_rd_data,
  output logic              y_wr_en,
  output logic [LEN_W-1:0]  y_wr_addr,
  output logic [ELEM_W-1:0] y_wr_data,
  output logic              done,
  output logic              overflow
);

  localparam int PROD_W = 2 * HALF_W + 2;
  localparam int ACC_W  = PROD_W + TAP_W;

  logic                    accept, rd_en, dat_vld, dat_first, wr_en, sat_event;
  logic signed [ACC_W-1:0] acc_re, acc_im;
  job_cfg_t                cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (accept) begin
      cfg_q.in_fmt   <= elem_fmt_e'(in_fmt);
      cfg_q.coef_fmt <= elem_fmt_e'(coef_fmt);
      cfg_q.out_fmt  <= elem_fmt_e'(out_fmt);
      cfg_q.conj     <= conj_coef;
    end
  end

  fir_seq_ctrl #(.MAX_TAPS(MAX_TAPS), .LEN_W(LEN_W), .TAP_W(TAP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .tap_count(tap_count), .data_len(data_len), .accept(accept),
    .rd_en(rd_en), .x_addr(x_rd_addr), .c_addr(c_rd_addr),
    .dat_vld(dat_vld), .dat_first(dat_first),
    .wr_en(wr_en), .wr_addr(y_wr_addr), .done(done)
  );

  fir_mac_unit #(.TAP_W(TAP_W), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .dat_vld(dat_vld), .dat_first(dat_first),
    .x_word(x_rd_data), .c_word(c_rd_data), .cfg(cfg_q),
    .acc_re(acc_re), .acc_im(acc_im)
  );

  fir_out_quant #(.ACC_W(ACC_W)) u_quant (
    .clk(clk), .rst_n(rst_n), .clr(accept), .wr_fire(wr_en),
    .acc_re(acc_re), .acc_im(acc_im), .out_fmt(cfg_q.out_fmt),
    .wr_data(y_wr_data), .sat_event(sat_event), .overflow(overflow)
  );

  assign x_rd_en = rd_en;
  assign c_rd_en = rd_en;
  assign y_wr_en = wr_en;

  AST_OVF_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(y_wr_en)); // R7
  AST_REAL_OUT_IM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (y_wr_en && !cfg_q.out_fmt[1]) |-> (y_wr_data[ELEM_W-1:HALF_W] == '0)); // R8
  AST_NO_READ_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    y_wr_en |-> !x_rd_en); // R2

endmodule

// File: tb/test_fir_valid_engine.sv
`timescale 1ns/1ps
module test_fir_valid_engine;
  localparam int MAX_TAPS = 16;
  localparam int LEN_W    = 8;
  localparam int TAP_W    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             start = 1'b0;
  logic [5:0]       op_code = '0;
  logic [TAP_W-1:0] tap_count = '0;
  logic [LEN_W-1:0] data_len = '0;
  logic [1:0]       in_fmt = '0, coef_fmt = '0, out_fmt = '0;
  logic             conj_coef = 1'b0;
  logic             x_rd_en, c_rd_en, y_wr_en, done, overflow;
  logic [LEN_W-1:0] x_rd_addr, y_wr_addr;
  logic [TAP_W-1:0] c_rd_addr;
  logic [63:0]      x_rd_data = '0, c_rd_data = '0, y_wr_data;

  logic [63:0] xmem [256];
  logic [63:0] cmem [32];

  fir_valid_engine #(.MAX_TAPS(MAX_TAPS), .LEN_W(LEN_W)) i_fir_valid_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .tap_count(tap_count), .data_len(data_len), .in_fmt(in_fmt),
    .coef_fmt(coef_fmt), .out_fmt(out_fmt), .conj_coef(conj_coef),
    .x_rd_en(x_rd_en), .x_rd_addr(x_rd_addr), .x_rd_data(x_rd_data),
    .c_rd_en(c_rd_en), .c_rd_addr(c_rd_addr), .c_rd_data(c_rd_data),
    .y_wr_en(y_wr_en), .y_wr_addr(y_wr_addr), .y_wr_data(y_wr_data),
    .done(done), .overflow(overflow)
  );

  always @(posedge clk) begin
    if (x_rd_en) x_rd_data <= xmem[x_rd_addr];
    if (c_rd_en) c_rd_data <= cmem[c_rd_addr];
  end

  int n_checks = 0, n_errs = 0, wr_seen = 0, done_seen = 0, cyc = 0;
  logic [LEN_W-1:0] eq_addr[$];
  logic [63:0]      eq_data[$];
  string            cur_tag = "R3";
  bit               prev_we = 0, prev_done = 0;
  longint unsigned  seed = 64'h1234_5678_9abc_def1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_errs++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  // Per-clock comparison against the expected write stream.
  always @(negedge clk) begin
    if (rst_n) begin
      if (y_wr_en) begin
        wr_seen++;
        if (eq_addr.size() == 0)
          check(1'b0, "R1", "write with none expected", 64'(y_wr_addr), 64'd0);
        else begin
          check(y_wr_addr == eq_addr[0], "R2", "write address", 64'(y_wr_addr), 64'(eq_addr[0]));
          check(y_wr_data == eq_data[0], cur_tag, "write data", y_wr_data, eq_data[0]);
          void'(eq_addr.pop_front());
          void'(eq_data.pop_front());
        end
      end
      if (done) begin
        done_seen++;
        check(prev_we && eq_addr.size() == 0, "R9", "done right after last write", 64'(prev_we), 64'd1);
        check(!prev_done, "R9", "done lasts one cycle", 64'(prev_done), 64'd0);
      end
      prev_we   = y_wr_en;
      prev_done = done;
    end
  end

  function automatic logic [63:0] rnd64();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  // Value of one lane on a Q31 grid (Q15 scaled by 2^16).
  function automatic logic signed [127:0] lane(logic [63:0] w, int fmt, bit imag);
    logic [31:0] h;
    if (imag && fmt < 2) return '0;
    h = imag ? w[63:32] : w[31:0];
    if (fmt % 2 == 1) return 128'(signed'(h[15:0])) * 128'sd65536;
    return 128'(signed'(h));
  endfunction

  function automatic logic [32:0] quant(logic signed [127:0] s, bit q15);
    logic signed [127:0] r, hi, lo;
    int sh;
    sh = q15 ? 47 : 31;
    hi = q15 ? 128'sd32767 : 128'sd2147483647;
    lo = -hi - 128'sd1;
    r  = (s + (128'sd1 <<< (sh - 1))) >>> sh;
    if (r > hi) return {1'b1, hi[31:0]};
    if (r < lo) return {1'b1, lo[31:0]};
    return {1'b0, r[31:0]};
  endfunction

  task automatic plan(input int taps, input int len, input int fi, input int fc,
                      input int fo, input bit cj, output bit ovf);
    ovf = 0;
    for (int n = 0; n <= len - taps; n++) begin
      logic signed [127:0] sr, si;
      logic [32:0] qr, qi;
      sr = 0; si = 0;
      for (int k = 0; k < taps; k++) begin
        logic signed [127:0] xr, xi, cr, ci;
        xr = lane(xmem[n+k], fi, 0); xi = lane(xmem[n+k], fi, 1);
        cr = lane(cmem[k], fc, 0);   ci = lane(cmem[k], fc, 1);
        if (cj) ci = -ci;
        sr += xr * cr - xi * ci;
        si += xr * ci + xi * cr;
      end
      qr = quant(sr, fo % 2 == 1);
      qi = quant(si, fo % 2 == 1);
      eq_addr.push_back(LEN_W'(n));
      eq_data.push_back({(fo >= 2) ? qi[31:0] : 32'd0, qr[31:0]});
      if (qr[32] || (fo >= 2 && qi[32])) ovf = 1;
    end
  endtask

  task automatic fill_random(input int len, input int taps);
    for (int i = 0; i < len; i++) xmem[i] = rnd64();
    for (int i = 0; i < taps; i++) cmem[i] = rnd64();
  endtask

  task automatic run_job(input string tag, input int opc, input int taps, input int len,
                         input int fi, input int fc, input int fo, input bit cj,
                         input bit go, input bit scramble);
    bit   ovf;
    int   wr0, dn0, waited;
    logic ovf_before;
    cur_tag = tag;
    ovf = 0;
    if (go) plan(taps, len, fi, fc, fo, cj, ovf);
    wr0 = wr_seen; dn0 = done_seen; ovf_before = overflow;
    @(negedge clk);
    op_code = 6'(opc); tap_count = TAP_W'(taps); data_len = LEN_W'(len);
    in_fmt = 2'(fi); coef_fmt = 2'(fc); out_fmt = 2'(fo); conj_coef = cj; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin  // R10: inputs change while running
      op_code = 6'd9; tap_count = TAP_W'(1); data_len = LEN_W'(3);
      in_fmt = ~in_fmt; coef_fmt = ~coef_fmt; out_fmt = ~out_fmt; conj_coef = ~conj_coef;
    end
    if (go) begin
      waited = 0;
      while (done_seen == dn0 && waited < 5000) begin @(posedge clk); waited++; end
      @(negedge clk);
      check(done_seen == dn0 + 1, "R9", "one done per command", 64'(done_seen - dn0), 64'd1);
      check(eq_addr.size() == 0, "R2", "results left unwritten", 64'(eq_addr.size()), 64'd0);
      check(wr_seen - wr0 == len - taps + 1, "R2", "write count", 64'(wr_seen - wr0), 64'(len - taps + 1));
      check(overflow == ovf, "R7", "overflow flag", 64'(overflow), 64'(ovf));
    end else begin
      repeat (40) @(negedge clk);
      check(wr_seen == wr0, "R1", "ignored start wrote", 64'(wr_seen - wr0), 64'd0);
      check(done_seen == dn0, "R1", "ignored start signalled done", 64'(done_seen - dn0), 64'd0);
      check(overflow == ovf_before, "R1", "ignored start changed overflow", 64'(overflow), 64'(ovf_before));
    end
    eq_addr.delete();
    eq_data.delete();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) xmem[i] = '0;
    for (int i = 0; i < 32; i++)  cmem[i] = '0;
    repeat (4) @(negedge clk);
    // R11: outputs quiet in reset
    check(!done && !overflow && !y_wr_en && !x_rd_en && !c_rd_en, "R11", "reset state",
          {59'd0, done, overflow, y_wr_en, x_rd_en, c_rd_en}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !overflow && !y_wr_en && !x_rd_en, "R11", "idle after reset",
          {60'd0, done, overflow, y_wr_en, x_rd_en}, 64'd0);

    // R3: real Q31 basic filter
    fill_random(10, 3);
    run_job("R3", 0, 3, 10, 0, 0, 0, 0, 1, 0);
    // R2: single tap and full-length single output at MAX_TAPS
    fill_random(5, 1);
    run_job("R2", 0, 1, 5, 0, 0, 0, 0, 1, 0);
    fill_random(16, 16);
    run_job("R2", 0, 16, 16, 2, 2, 2, 0, 1, 0);
    // R5: complex Q31 with and without conjugation
    fill_random(12, 4);
    run_job("R5", 0, 4, 12, 2, 2, 2, 0, 1, 0);
    run_job("R5", 0, 4, 12, 2, 2, 2, 1, 1, 0);
    // R4 / R8: Q15 lanes with junk upper bits, complex Q15 and real Q15 outputs
    fill_random(9, 3);
    run_job("R4", 0, 3, 9, 3, 3, 3, 1, 1, 0);
    run_job("R8", 0, 3, 9, 3, 1, 1, 0, 1, 0);
    run_job("R8", 0, 3, 9, 2, 0, 0, 1, 1, 0);

    // R6: rounding midpoints, coefficient 0.5
    cmem[0] = 64'hDEAD_BEEF_4000_0000;
    xmem[0] = 64'h0000_0000_0000_0001;
    xmem[1] = 64'h0000_0000_FFFF_FFFF;
    xmem[2] = 64'h0000_0000_0000_0003;
    xmem[3] = 64'h0000_0000_FFFF_FFFD;
    run_job("R6", 0, 1, 4, 0, 0, 0, 0, 1, 0);

    // R7: positive clamp (-1 * -1) then ignored starts keep the flag
    cmem[0] = 64'h0000_0000_8000_0000;
    xmem[0] = 64'h0000_0000_8000_0000;
    xmem[1] = 64'h0000_0000_4000_0000;
    run_job("R7", 0, 1, 2, 0, 0, 0, 0, 1, 0);
    check(overflow == 1'b1, "R7", "flag after positive clamp", 64'(overflow), 64'd1);
    run_job("R1", 2, 1, 2, 0, 0, 0, 0, 0, 0);
    run_job("R1", 0, 0, 4, 0, 0, 0, 0, 0, 0);
    run_job("R1", 0, 17, 20, 0, 0, 0, 0, 0, 0);
    run_job("R1", 0, 5, 4, 0, 0, 0, 0, 0, 0);
    // R7: accepted command clears the flag
    xmem[0] = 64'd1; xmem[1] = 64'd2; cmem[0] = 64'h0000_0000_2000_0000;
    run_job("R7", 0, 1, 2, 0, 0, 0, 0, 1, 0);
    // R7: negative clamp in Q15
    cmem[0] = 64'h7FFF; cmem[1] = 64'h7FFF;
    xmem[0] = 64'h8000; xmem[1] = 64'h8000; xmem[2] = 64'h8000;
    run_job("R7", 0, 2, 3, 1, 1, 1, 0, 1, 0);

    // R10: configuration changes mid-command are ignored
    fill_random(14, 5);
    run_job("R10", 0, 5, 14, 3, 2, 2, 1, 1, 1);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule